// File: doc/BRIEF.md
# Pipeline Stage Register with Hold and Bubble Modes

This block is the clocked register that sits between two stages of an in-order pipeline. It holds one instruction's bundle of fields: an instruction code, a function code, a status code, a set of register identifiers and a set of data words. Every field width and count is a parameter. Two control inputs pick what happens at each rising clock edge. The register can take the incoming bundle, keep what it already holds, or replace its contents with a fixed "do nothing" encoding.

That encoding is the same as a real no-operation instruction. Its register identifiers all name "no register", so a bubble moves down the later stages without writing anything and without creating a dependency. Both control inputs may never be high together. If they are, the register keeps its contents and raises an error flag. The flag stays high until the next reset.

The pipeline control logic drives the two controls, and the stage datapath drives the field inputs. Neither is part of this block.

Top module: `stage_pipe_reg`

## Requirements
- R1: At a rising edge with `rst_n` low, every field loads the nop pattern and `err_flag` clears, whatever `stall` and `bubble` are. The nop pattern is: `q_icode` = NOP_CODE (default 1), `q_ifun` = 0, `q_stat` = OK_STAT (default 1), every register identifier all ones (0xF), and every data word zero.
- R2: At a rising edge with `rst_n` high, `stall` = 0 and `bubble` = 0, every output field takes the value of its input at that edge.
- R3: At a rising edge with `stall` = 1 and `bubble` = 0, every output field keeps its previous value.
- R4: At a rising edge with `stall` = 0 and `bubble` = 1, every output field takes the nop pattern defined in R1.
- R5: At a rising edge with both `stall` and `bubble` high, every output field keeps its previous value and `err_flag` is 1 after that edge.
- R6: Once set, `err_flag` stays at 1 through any later mode until a reset edge clears it. Before any such clash it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, loads the nop pattern |
| stall | input | 1 | Hold the current contents |
| bubble | input | 1 | Load the nop pattern |
| d_icode | input | CODE_W | Incoming instruction code |
| d_ifun | input | CODE_W | Incoming function code |
| d_stat | input | STAT_W | Incoming status code |
| d_reg_ids | input | NUM_ID x REG_W | Incoming register identifiers |
| d_vals | input | NUM_VAL x DATA_W | Incoming data words |
| q_icode | output | CODE_W | Registered instruction code |
| q_ifun | output | CODE_W | Registered function code |
| q_stat | output | STAT_W | Registered status code |
| q_reg_ids | output | NUM_ID x REG_W | Registered register identifiers |
| q_vals | output | NUM_VAL x DATA_W | Registered data words |
| err_flag | output | 1 | Sticky flag set when stall and bubble coincide |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. Field loads, holds, bubbles, reset and the error flag all come out of a single register level. The bench drives the controls and fields on the falling edge. It lets one rising edge capture them and compares all outputs at the next falling edge, against a model it updates from the requirement for that mode. For a hold or a clash, the fields are driven with fresh values, so a wrong load shows up at the ports.

// File: rtl/stage_reg_pkg.sv
// Package: shared mode type for the stage register and its helpers.
// Assumes: the two control inputs are decoded into exactly one mode per cycle.
package stage_reg_pkg;

    // Update mode of the stage register at the next rising edge.
    typedef enum logic [1:0] {
        SR_LOAD   = 2'd0,
        SR_HOLD   = 2'd1,
        SR_BUBBLE = 2'd2,
        SR_CLASH  = 2'd3
    } sr_mode_e;

    // Map the two control wires onto a mode.
    function automatic sr_mode_e sr_decode(input logic hold_req, input logic nop_req);
        sr_mode_e m;
        unique case ({hold_req, nop_req})
            2'b00:   m = SR_LOAD;
            2'b10:   m = SR_HOLD;
            2'b01:   m = SR_BUBBLE;
            default: m = SR_CLASH;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/stage_mode_decode.sv
// Module: stage_mode_decode
// Turns the stall and bubble controls into one update mode.
// Assumes: the controls are stable around the rising edge; purely combinational.
module stage_mode_decode
    import stage_reg_pkg::*;
(
    input  logic     stall,
    input  logic     bubble,
    output sr_mode_e mode
);

    // Decode the control pair into a mode.
    always_comb begin
        mode = sr_decode(stall, bubble);
    end

endmodule

// File: rtl/stage_field_reg.sv
// Module: stage_field_reg
// One field of the stage register. It loads, holds or takes its nop value
// according to the mode. A clash holds, so the contents are not corrupted.
// Assumes: the reset is synchronous and active low, and loads the nop value.
module stage_field_reg
    import stage_reg_pkg::*;
#(
    parameter int          W       = 8,
    parameter logic [W-1:0] NOP_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sr_mode_e     mode,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] q_r;
    logic [W-1:0] nxt;

    // Select the next value of the field from the mode.
    always_comb begin
        unique case (mode)
            SR_LOAD:   nxt = d;
            SR_BUBBLE: nxt = NOP_VAL;
            default:   nxt = q_r;
        endcase
    end

    // Field storage with synchronous reset to the nop value.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= NOP_VAL;
        else        q_r <= nxt;
    end

    assign q = q_r;

endmodule

// File: rtl/stage_fault_flag.sv
// Module: stage_fault_flag
// Sticky flag that records a stall/bubble clash at a clock edge.
// Assumes: only a reset clears it; the flag is registered, not combinational.
module stage_fault_flag
    import stage_reg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sr_mode_e mode,
    output logic     flag
);

    logic flag_r;

    // Set on a clash and keep it set until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_r <= 1'b0;
        else if (mode == SR_CLASH) flag_r <= 1'b1;
    end

    assign flag = flag_r;

endmodule

// File: rtl/stage_pipe_reg.sv
// Module: stage_pipe_reg
// Pipeline stage register for one instruction bundle. The modes are load,
// hold and bubble. A bubble writes a nop with empty register identifiers,
// an OK status and zero data. A clash of the two controls holds the contents
// and sets a sticky error flag.
// Assumes: synchronous active-low reset; the controls come from outside.
module stage_pipe_reg
    import stage_reg_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int STAT_W  = 3,
    parameter int REG_W   = 4,
    parameter int NUM_ID  = 4,
    parameter int DATA_W  = 64,
    parameter int NUM_VAL = 3,
    parameter int NOP_CODE = 1,
    parameter int OK_STAT  = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             stall,
    input  logic                             bubble,
    input  logic [CODE_W-1:0]                d_icode,
    input  logic [CODE_W-1:0]                d_ifun,
    input  logic [STAT_W-1:0]                d_stat,
    input  logic [NUM_ID-1:0][REG_W-1:0]     d_reg_ids,
    input  logic [NUM_VAL-1:0][DATA_W-1:0]   d_vals,
    output logic [CODE_W-1:0]                q_icode,
    output logic [CODE_W-1:0]                q_ifun,
    output logic [STAT_W-1:0]                q_stat,
    output logic [NUM_ID-1:0][REG_W-1:0]     q_reg_ids,
    output logic [NUM_VAL-1:0][DATA_W-1:0]   q_vals,
    output logic                             err_flag
);

    localparam logic [CODE_W-1:0] NOP_ICODE = CODE_W'(NOP_CODE);
    localparam logic [STAT_W-1:0] NOP_STAT  = STAT_W'(OK_STAT);
    localparam logic [REG_W-1:0]  NO_REG    = {REG_W{1'b1}};

    sr_mode_e mode;

    stage_mode_decode u_decode (
        .stall  (stall),
        .bubble (bubble),
        .mode   (mode)
    );

    stage_field_reg #(.W(CODE_W), .NOP_VAL(NOP_ICODE)) u_icode (
        .clk(clk), .rst_n(rst_n), .mode(mode), .d(d_icode), .q(q_icode)
    );

    stage_field_reg #(.W(CODE_W), .NOP_VAL({CODE_W{1'b0}})) u_ifun (
        .clk(clk), .rst_n(rst_n), .mode(mode), .d(d_ifun), .q(q_ifun)
    );

    stage_field_reg #(.W(STAT_W), .NOP_VAL(NOP_STAT)) u_stat (
        .clk(clk), .rst_n(rst_n), .mode(mode), .d(d_stat), .q(q_stat)
    );

    // One register per register identifier; a bubble marks each one empty.
    for (genvar gi = 0; gi < NUM_ID; gi++) begin : g_id
        stage_field_reg #(.W(REG_W), .NOP_VAL(NO_REG)) u_id (
            .clk(clk), .rst_n(rst_n), .mode(mode),
            .d(d_reg_ids[gi]), .q(q_reg_ids[gi])
        );
    end

    // One register per data word; a bubble clears each one.
    for (genvar gv = 0; gv < NUM_VAL; gv++) begin : g_val
        stage_field_reg #(.W(DATA_W), .NOP_VAL({DATA_W{1'b0}})) u_val (
            .clk(clk), .rst_n(rst_n), .mode(mode),
            .d(d_vals[gv]), .q(q_vals[gv])
        );
    end

    stage_fault_flag u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .flag  (err_flag)
    );

endmodule

// File: rtl/stage_pipe_reg_chk.sv
// Module: stage_pipe_reg_chk
// Checker bound to stage_pipe_reg. It relates the controls and inputs at one
// edge to the outputs after that edge.
// Assumes: the default field widths; it observes ports only.
module stage_pipe_reg_chk #(
    parameter int CODE_W  = 4,
    parameter int STAT_W  = 3,
    parameter int REG_W   = 4,
    parameter int NUM_ID  = 4,
    parameter int DATA_W  = 64,
    parameter int NUM_VAL = 3,
    parameter int NOP_CODE = 1,
    parameter int OK_STAT  = 1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           stall,
    input logic                           bubble,
    input logic [CODE_W-1:0]              d_icode,
    input logic [NUM_ID-1:0][REG_W-1:0]   d_reg_ids,
    input logic [NUM_VAL-1:0][DATA_W-1:0] d_vals,
    input logic [CODE_W-1:0]              q_icode,
    input logic [STAT_W-1:0]              q_stat,
    input logic [NUM_ID-1:0][REG_W-1:0]   q_reg_ids,
    input logic [NUM_VAL-1:0][DATA_W-1:0] q_vals,
    input logic                           err_flag
);

    // R2
    load_takes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !bubble) |=> (q_icode == $past(d_icode) && q_reg_ids == $past(d_reg_ids)
                                 && q_vals == $past(d_vals)));

    // R3
    stall_keeps_contents_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !bubble) |=> ($stable(q_icode) && $stable(q_reg_ids) && $stable(q_vals)));

    // R4
    bubble_gives_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble && !stall) |=> (q_icode == CODE_W'(NOP_CODE) && q_stat == STAT_W'(OK_STAT)
                                && q_reg_ids == '1 && q_vals == '0));

    // R5
    clash_sets_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && bubble) |=> (err_flag && $stable(q_icode) && $stable(q_vals)));

    // R6
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind stage_pipe_reg stage_pipe_reg_chk #(
    .CODE_W(CODE_W), .STAT_W(STAT_W), .REG_W(REG_W), .NUM_ID(NUM_ID),
    .DATA_W(DATA_W), .NUM_VAL(NUM_VAL), .NOP_CODE(NOP_CODE), .OK_STAT(OK_STAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .stall(stall), .bubble(bubble),
    .d_icode(d_icode), .d_reg_ids(d_reg_ids), .d_vals(d_vals),
    .q_icode(q_icode), .q_stat(q_stat), .q_reg_ids(q_reg_ids),
    .q_vals(q_vals), .err_flag(err_flag)
);

// File: tb/stage_pipe_reg_tb.sv
// Bench for stage_pipe_reg: a table of mode vectors, then directed tests
// for reset, the stall/bubble clash and the sticky error flag.
module stage_pipe_reg_tb;

    localparam int CODE_W = 4, STAT_W = 3, REG_W = 4, NUM_ID = 4;
    localparam int DATA_W = 64, NUM_VAL = 3;
    localparam int SRC_NEW = 0, SRC_OLD = 1, SRC_NOP = 2;

    // {expected source[1:0], stall, bubble, seed[7:0]}
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [0:NVEC-1] = '{
        {2'd0, 2'b00, 8'hA5}, {2'd1, 2'b10, 8'h3C}, {2'd1, 2'b10, 8'h71},
        {2'd0, 2'b00, 8'h0E}, {2'd2, 2'b01, 8'h55}, {2'd0, 2'b00, 8'hF0},
        {2'd0, 2'b00, 8'h12}, {2'd2, 2'b01, 8'h9A}, {2'd2, 2'b01, 8'h33},
        {2'd1, 2'b10, 8'h44}, {2'd0, 2'b00, 8'h87}, {2'd1, 2'b10, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n, stall, bubble;
    logic [CODE_W-1:0] d_icode, d_ifun, q_icode, q_ifun;
    logic [STAT_W-1:0] d_stat, q_stat;
    logic [NUM_ID-1:0][REG_W-1:0] d_reg_ids, q_reg_ids;
    logic [NUM_VAL-1:0][DATA_W-1:0] d_vals, q_vals;
    logic err_flag;

    logic [CODE_W-1:0] e_icode, e_ifun;
    logic [STAT_W-1:0] e_stat;
    logic [NUM_ID-1:0][REG_W-1:0] e_ids;
    logic [NUM_VAL-1:0][DATA_W-1:0] e_vals;
    logic e_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stage_pipe_reg u_dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .bubble(bubble),
        .d_icode(d_icode), .d_ifun(d_ifun), .d_stat(d_stat),
        .d_reg_ids(d_reg_ids), .d_vals(d_vals),
        .q_icode(q_icode), .q_ifun(q_ifun), .q_stat(q_stat),
        .q_reg_ids(q_reg_ids), .q_vals(q_vals), .err_flag(err_flag)
    );

    task automatic drive_seed(input logic [7:0] s);
        d_icode = s[3:0];
        d_ifun  = s[7:4];
        d_stat  = s[2:0] ^ 3'd5;
        for (int k = 0; k < NUM_ID; k++) d_reg_ids[k] = s[3:0] + REG_W'(k);
        for (int k = 0; k < NUM_VAL; k++) d_vals[k] = {8{s}} ^ (64'(k + 1) << (8 * k));
    endtask

    task automatic model_new();
        e_icode = d_icode; e_ifun = d_ifun; e_stat = d_stat;
        e_ids = d_reg_ids; e_vals = d_vals;
    endtask

    task automatic model_nop();
        e_icode = 4'd1; e_ifun = 4'd0; e_stat = 3'd1;
        e_ids = '1; e_vals = '0;
    endtask

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "icode", 64'(q_icode), 64'(e_icode));
        chk(req, "ifun", 64'(q_ifun), 64'(e_ifun));
        chk(req, "stat", 64'(q_stat), 64'(e_stat));
        chk(req, "reg_ids", 64'(q_reg_ids), 64'(e_ids));
        for (int k = 0; k < NUM_VAL; k++) chk(req, "val", q_vals[k], e_vals[k]);
        chk(req, "err_flag", 64'(err_flag), 64'(e_err));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stall = 1'b0; bubble = 1'b0;
        drive_seed(8'h6B);
        @(negedge clk);
        step();
        // R1: reset loads the nop pattern, error clear
        model_nop(); e_err = 1'b0;
        chk_all("R1");

        rst_n = 1'b1;
        // Table walk: R2 load, R3 hold, R4 bubble
        for (int i = 0; i < NVEC; i++) begin
            stall  = VEC[i][9];
            bubble = VEC[i][8];
            drive_seed(VEC[i][7:0]);
            step();
            case (int'(VEC[i][11:10]))
                SRC_NEW: model_new();
                SRC_NOP: model_nop();
                default: ;
            endcase
            case (int'(VEC[i][11:10]))
                SRC_NEW: chk_all("R2");
                SRC_OLD: chk_all("R3");
                default: chk_all("R4");
            endcase
        end

        // R5: clash holds contents and raises the flag
        stall = 1'b0; bubble = 1'b0; drive_seed(8'hC3);
        step(); model_new();
        stall = 1'b1; bubble = 1'b1; drive_seed(8'h29);
        step(); e_err = 1'b1;
        chk_all("R5");

        // R6: flag stays set through a load and a bubble
        stall = 1'b0; bubble = 1'b0; drive_seed(8'h5E);
        step(); model_new();
        chk_all("R6");
        bubble = 1'b1;
        step(); model_nop();
        chk_all("R6");

        // R1: reset overrides stall and clears the flag
        stall = 1'b0; bubble = 1'b0; drive_seed(8'hB7);
        step(); model_new();
        rst_n = 1'b0; stall = 1'b1; drive_seed(8'h1D);
        step(); model_nop(); e_err = 1'b0;
        chk_all("R1");

        // R6: flag stays clear after reset with legal modes
        rst_n = 1'b1; stall = 1'b0; drive_seed(8'hE4);
        step(); model_new();
        chk_all("R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule